// File: doc/BRIEF.md
# Self-Checking Boundary Scan Pin Cell

This block is the test-access slice for one device pin. It sits between the core logic and the pad, and it is controlled by the strobes that a test access port controller decodes: shift, capture, update, test mode and test reset. The pin's output enable has a control bit of its own in the serial chain. In test mode the pad can therefore be driven and sensed in the same cycle. During capture, the cell records the level it reads back at the pad, not the value the core meant to drive. A driver that is open, or a pad held at 0 or 1 from outside, shows up directly in the shifted-out data.

A static protection input turns on self-checking of the drive. While the cell drives the pad in test mode, it compares the driven level with the sensed level. On a mismatch it sets a sticky fault flag, and the flag inverts the driven level so that the driver stops fighting the external fault. The flag is the third bit of the cell's chain. Each capture samples the flag and then re-arms it, so the fault is checked again after every capture.

A parameter selects a second variant for time-critical clock inputs. That variant has only a one-bit capture/shift stage, never drives the pad, and has no update stage.

Top module: `bsc_pin_cell`

## Requirements
- R1: On a rising tck edge with tst_rst high, the chain bits and the fault flag go to 0. On a falling edge with tst_rst high, the latched enable and data go to 0. After reset with mode=1, pad_oe=0 (pad released) and pad_out=0.
- R2: With mode=0, pad_out equals core_dout and pad_oe equals core_oe, whatever the scan strobes do.
- R3: On a rising tck edge with shift_dr=1, the three-bit chain moves one place: bit 0 (enable control) takes scan_in, bit 1 (data) takes bit 0, bit 2 (fault status) takes bit 1. scan_out is bit 2. Shift wins over capture.
- R4: On a rising edge with capture_dr=1 and shift_dr=0, bit 0 loads pad_oe, bit 1 loads the sensed pad level pad_in, and bit 2 loads the fault flag.
- R5: On a falling tck edge with update_dr=1, the enable latch loads chain bit 0 and the data latch loads chain bit 1. Otherwise both latches hold.
- R6: With mode=1, pad_oe equals the enable latch and pad_out equals the data latch, inverted while the fault flag is set.
- R7: core_din always follows pad_in, including cycles in which the cell drives the pad.
- R8: The fault flag sets on a rising edge when mode=1, unstress_en=1, pad_oe=1 and pad_out differs from pad_in. The flag takes priority over a capture in the same cycle.
- R9: With no mismatch, a capture clears the fault flag. With unstress_en=0 the flag never sets, and the driven level is never inverted.
- R10: With KIND set to the clock capture variant, pad_oe and pad_out stay 0. The single chain bit captures pad_in, shifts from scan_in and drives scan_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tst_rst | input | 1 | Test logic reset, synchronous, active high |
| shift_dr | input | 1 | Shift strobe for the chain |
| capture_dr | input | 1 | Capture strobe for the chain |
| update_dr | input | 1 | Update strobe, acts on falling tck |
| mode | input | 1 | 1 selects the latched test values for the pad |
| unstress_en | input | 1 | Static enable for drive self-checking |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out |
| core_dout | input | 1 | Core output value |
| core_oe | input | 1 | Core output enable |
| core_din | output | 1 | Pad level passed to the core |
| pad_out | output | 1 | Value to the pad driver |
| pad_oe | output | 1 | Pad driver enable |
| pad_in | input | 1 | Level sensed at the pad |

## Verification
The difficult overlap is a capture that falls in the same cycle as a drive/sense mismatch. In that cycle the chain must take the old flag and the real pad level, while the flag itself decides whether it re-arms or stays set. The bench models the pad in a way that can hold it at a chosen level against the driver. It then mixes random strobes, stuck faults, mode changes and protection enables, so that captures land both on freshly flipped drives and on drives that still conflict with the pad. A bench reference model that follows the requirements predicts the pad value, the enable, the scan output and the core input every cycle. Directed sequences then pin down the literal flip, re-arm and disable behaviour.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [0:0] {
        KIND_IO      = 1'b0,
        KIND_CLK_CAP = 1'b1
    } cell_kind_e;

    // value and enable toward the pad, also the shape of the update stage
    typedef struct packed {
        logic oe;
        logic val;
    } drive_t;

    localparam int unsigned IO_CHAIN_LEN  = 3;
    localparam int unsigned CLK_CHAIN_LEN = 1;

    // chain positions, counted from scan_in
    localparam int unsigned POS_CTL  = 0;
    localparam int unsigned POS_DAT  = 1;
    localparam int unsigned POS_STAT = 2;

    function automatic int unsigned chain_len(cell_kind_e k);
        return (k == KIND_IO) ? IO_CHAIN_LEN : CLK_CHAIN_LEN;
    endfunction

    function automatic drive_t pick_drive(logic test_mode, drive_t core,
                                          drive_t latched, logic flip);
        drive_t d;
        if (test_mode) begin
            d.oe  = latched.oe;
            d.val = latched.val ^ flip;
        end else begin
            d = core;
        end
        return d;
    endfunction

endpackage

// File: rtl/bsc_scan_reg.sv
module bsc_scan_reg #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         capture_en,
    input  logic         si,
    input  logic [N-1:0] cap_d,
    output logic [N-1:0] q
);

    // shift has priority over capture
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (shift_en) begin
            q[0] <= si;
            for (int i = 1; i < int'(N); i++) begin
                q[i] <= q[i-1];
            end
        end else if (capture_en) begin
            q <= cap_d;
        end
    end

endmodule

// File: rtl/bsc_update_latch.sv
module bsc_update_latch
    import bsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  drive_t d,
    output drive_t q
);

    // update stage acts on the falling edge, half a cycle after shift/capture
    always_ff @(negedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/bsc_unstress.sv
module bsc_unstress (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic drv_oe,
    input  logic drv_val,
    input  logic sense,
    input  logic clear,
    output logic flag
);

    logic mism;

    assign mism = arm & drv_oe & (drv_val ^ sense);

    // a live mismatch outranks the clear that a capture requests
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (mism) begin
            flag <= 1'b1;
        end else if (clear) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/bsc_pad_drive.sv
module bsc_pad_drive
    import bsc_pkg::*;
(
    input  logic   test_mode,
    input  drive_t core,
    input  drive_t latched,
    input  logic   flip,
    output drive_t pad
);

    always_comb begin
        pad = pick_drive(test_mode, core, latched, flip);
    end

endmodule

// File: rtl/bsc_pin_cell.sv
module bsc_pin_cell
    import bsc_pkg::*;
#(
    parameter cell_kind_e KIND = KIND_IO
) (
    input  logic tck,
    input  logic tst_rst,
    input  logic shift_dr,
    input  logic capture_dr,
    input  logic update_dr,
    input  logic mode,
    input  logic unstress_en,
    input  logic scan_in,
    output logic scan_out,
    input  logic core_dout,
    input  logic core_oe,
    output logic core_din,
    output logic pad_out,
    output logic pad_oe,
    input  logic pad_in
);

    localparam int unsigned CHAIN_LEN = chain_len(KIND);

    logic [CHAIN_LEN-1:0] chain_q;
    logic [CHAIN_LEN-1:0] chain_cap;
    drive_t               upd_q;
    logic                 flag_q;

    // input path never passes through a mux
    assign core_din = pad_in;
    assign scan_out = chain_q[CHAIN_LEN-1];

    bsc_scan_reg #(.N(CHAIN_LEN)) u_chain (
        .clk        (tck),
        .rst        (tst_rst),
        .shift_en   (shift_dr),
        .capture_en (capture_dr),
        .si         (scan_in),
        .cap_d      (chain_cap),
        .q          (chain_q)
    );

    generate
        if (KIND == KIND_IO) begin : g_io
            drive_t core_drv;
            drive_t upd_d;
            drive_t pad_drv;

            assign core_drv.oe  = core_oe;
            assign core_drv.val = core_dout;
            assign upd_d.oe     = chain_q[POS_CTL];
            assign upd_d.val    = chain_q[POS_DAT];

            assign chain_cap[POS_CTL]  = pad_oe;
            assign chain_cap[POS_DAT]  = pad_in;
            assign chain_cap[POS_STAT] = flag_q;

            bsc_update_latch u_upd (
                .clk  (tck),
                .rst  (tst_rst),
                .load (update_dr),
                .d    (upd_d),
                .q    (upd_q)
            );

            bsc_unstress u_guard (
                .clk     (tck),
                .rst     (tst_rst),
                .arm     (mode & unstress_en),
                .drv_oe  (pad_oe),
                .drv_val (pad_out),
                .sense   (pad_in),
                .clear   (capture_dr),
                .flag    (flag_q)
            );

            bsc_pad_drive u_mux (
                .test_mode (mode),
                .core      (core_drv),
                .latched   (upd_q),
                .flip      (flag_q),
                .pad       (pad_drv)
            );

            assign pad_out = pad_drv.val;
            assign pad_oe  = pad_drv.oe;
        end else begin : g_clk
            // observe only: nothing stands in the functional clock path
            assign chain_cap = pad_in;
            assign upd_q     = '0;
            assign flag_q    = 1'b0;
            assign pad_out   = 1'b0;
            assign pad_oe    = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/bsc_pin_cell_chk.sv
module bsc_pin_cell_chk
    import bsc_pkg::*;
#(
    parameter cell_kind_e  KIND      = KIND_IO,
    parameter int unsigned CHAIN_LEN = 3
) (
    input logic                 tck,
    input logic                 tst_rst,
    input logic                 shift_dr,
    input logic                 capture_dr,
    input logic                 update_dr,
    input logic                 mode,
    input logic                 unstress_en,
    input logic                 scan_out,
    input logic                 core_dout,
    input logic                 core_oe,
    input logic                 pad_out,
    input logic                 pad_oe,
    input logic                 pad_in,
    input logic [CHAIN_LEN-1:0] chain_q,
    input drive_t               upd_q,
    input logic                 flag_q
);

    generate
        if (KIND == KIND_IO) begin : g_io_chk
            a_r1_reset_clears: assert property (@(posedge tck) disable iff (tst_rst)
                $fell(tst_rst) |-> (!flag_q && chain_q == '0));

            a_r2_func_path: assert property (@(posedge tck) disable iff (tst_rst)
                !mode |-> (pad_out == core_dout && pad_oe == core_oe));

            a_r3_shift_out: assert property (@(posedge tck) disable iff (tst_rst)
                shift_dr |=> (scan_out == $past(chain_q[CHAIN_LEN-2])));

            a_r4_capture_readback: assert property (@(posedge tck) disable iff (tst_rst)
                (capture_dr && !shift_dr) |=> (chain_q[POS_DAT] == $past(pad_in)));

            a_r5_hold_without_update: assert property (@(negedge tck) disable iff (tst_rst)
                (!$past(update_dr) && !$past(tst_rst)) |-> $stable(upd_q));

            a_r6_enable_from_latch: assert property (@(posedge tck) disable iff (tst_rst)
                mode |-> (pad_oe == upd_q.oe));

            a_r8_flag_sets: assert property (@(posedge tck) disable iff (tst_rst)
                (mode && unstress_en && pad_oe && (pad_out != pad_in)) |=> flag_q);

            a_r8_flip_drive: assert property (@(posedge tck) disable iff (tst_rst)
                (mode && flag_q) |-> (pad_out == !upd_q.val));

            a_r9_stays_clear_when_off: assert property (@(posedge tck) disable iff (tst_rst)
                (!unstress_en && !flag_q) |=> !flag_q);
        end else begin : g_clk_chk
            a_r10_never_drives: assert property (@(posedge tck) disable iff (tst_rst)
                (!pad_oe && !pad_out));

            a_r10_capture_pin: assert property (@(posedge tck) disable iff (tst_rst)
                (capture_dr && !shift_dr) |=> (scan_out == $past(pad_in)));
        end
    endgenerate

endmodule

bind bsc_pin_cell bsc_pin_cell_chk #(
    .KIND      (KIND),
    .CHAIN_LEN (CHAIN_LEN)
) u_chk (
    .tck         (tck),
    .tst_rst     (tst_rst),
    .shift_dr    (shift_dr),
    .capture_dr  (capture_dr),
    .update_dr   (update_dr),
    .mode        (mode),
    .unstress_en (unstress_en),
    .scan_out    (scan_out),
    .core_dout   (core_dout),
    .core_oe     (core_oe),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_in      (pad_in),
    .chain_q     (chain_q),
    .upd_q       (upd_q),
    .flag_q      (flag_q)
);

// File: tb/tb_bsc_pin_cell.sv
module tb_bsc_pin_cell;
    import bsc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 20240611;
    localparam int N_RANDOM   = 400;

    logic tck = 1'b0;
    logic tst_rst, shift_dr, capture_dr, update_dr, mode, unstress_en, scan_in;
    logic core_dout, core_oe;
    logic ext_val, ext_c, stuck_en, stuck_val;
    logic scan_out, core_din, pad_out, pad_oe, pad_in;
    logic scan_out_c, core_din_c, pad_out_c, pad_oe_c;

    int n_chk  = 0;
    int n_fail = 0;

    // bench reference state
    logic [2:0] m_q;
    logic       m_uoe, m_udat, m_flag, m_cq;

    always #(CLK_PERIOD/2) tck = ~tck;

    // pad: a stuck fault overrides the driver, otherwise the driver or the outside
    assign pad_in = stuck_en ? stuck_val : (pad_oe ? pad_out : ext_val);

    bsc_pin_cell #(.KIND(KIND_IO)) dut (
        .tck(tck), .tst_rst(tst_rst), .shift_dr(shift_dr), .capture_dr(capture_dr),
        .update_dr(update_dr), .mode(mode), .unstress_en(unstress_en),
        .scan_in(scan_in), .scan_out(scan_out), .core_dout(core_dout),
        .core_oe(core_oe), .core_din(core_din), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_in(pad_in)
    );

    bsc_pin_cell #(.KIND(KIND_CLK_CAP)) dut_clk (
        .tck(tck), .tst_rst(tst_rst), .shift_dr(shift_dr), .capture_dr(capture_dr),
        .update_dr(update_dr), .mode(mode), .unstress_en(unstress_en),
        .scan_in(scan_in), .scan_out(scan_out_c), .core_dout(core_dout),
        .core_oe(core_oe), .core_din(core_din_c), .pad_out(pad_out_c),
        .pad_oe(pad_oe_c), .pad_in(ext_c)
    );

    function automatic logic exp_oe();
        return mode ? m_uoe : core_oe;
    endfunction

    function automatic logic exp_out();
        return mode ? (m_udat ^ m_flag) : core_dout;
    endfunction

    function automatic logic exp_pin();
        return stuck_en ? stuck_val : (exp_oe() ? exp_out() : ext_val);
    endfunction

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // advance the model over one falling then one rising edge
    task automatic model_cycle();
        logic eo, ed, pin, mm;
        if (tst_rst) begin
            m_q = '0; m_uoe = 1'b0; m_udat = 1'b0; m_flag = 1'b0; m_cq = 1'b0;
            return;
        end
        if (update_dr) begin
            m_uoe  = m_q[0];
            m_udat = m_q[1];
        end
        eo  = exp_oe();
        ed  = exp_out();
        pin = exp_pin();
        mm  = mode && unstress_en && eo && (ed != pin);
        if (shift_dr)        m_q = {m_q[1:0], scan_in};
        else if (capture_dr) m_q = {m_flag, pin, eo};
        m_flag = mm | (m_flag & ~capture_dr);
        if (shift_dr)        m_cq = scan_in;
        else if (capture_dr) m_cq = ext_c;
    endtask

    task automatic step(input logic sh, input logic cap, input logic up);
        shift_dr = sh; capture_dr = cap; update_dr = up;
        model_cycle();
        @(posedge tck);
        #2;
    endtask

    task automatic check_all();
        chk("R6 R8 R2 pad_out", pad_out, exp_out());
        chk("R6 R1 R2 pad_oe", pad_oe, exp_oe());
        chk("R3 R4 scan_out", scan_out, m_q[2]);
        chk("R7 core_din", core_din, exp_pin());
        chk("R10 clk scan_out", scan_out_c, m_cq);
        chk("R10 clk pad_oe", pad_oe_c, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned r;
        r = $urandom(SEED);
        tst_rst = 1'b1; shift_dr = 0; capture_dr = 0; update_dr = 0;
        mode = 1'b1; unstress_en = 1'b0; scan_in = 0;
        core_dout = 1'b1; core_oe = 1'b1;
        ext_val = 0; ext_c = 0; stuck_en = 0; stuck_val = 0;
        m_q = '0; m_uoe = 0; m_udat = 0; m_flag = 0; m_cq = 0;
        @(posedge tck); #2;
        repeat (3) step(0, 0, 0);
        tst_rst = 1'b0;
        step(0, 0, 0);

        // R1: released pad after reset in test mode
        chk("R1 pad_oe after reset", pad_oe, 1'b0);
        chk("R1 pad_out after reset", pad_out, 1'b0);
        chk("R1 scan_out after reset", scan_out, 1'b0);

        // R3 R5 R6: load enable=1 data=1 (last bit shifted lands in the enable bit)
        scan_in = 0; step(1, 0, 0);
        scan_in = 1; step(1, 0, 0);
        scan_in = 1; step(1, 0, 0);
        chk("R5 no update yet", pad_oe, 1'b0);
        step(0, 0, 1);
        chk("R5 R6 pad_oe after update", pad_oe, 1'b1);
        chk("R5 R6 pad_out after update", pad_out, 1'b1);

        // R4 R7: capture with healthy pad reads back driven 1
        step(0, 1, 0);
        chk("R4 status bit", scan_out, 1'b0);
        chk("R7 core_din while driving", core_din, 1'b1);

        // R8: pad held at 0 while driving 1
        unstress_en = 1'b1; stuck_en = 1'b1; stuck_val = 1'b0;
        chk("R8 before detect", pad_out, 1'b1);
        step(0, 0, 0);
        chk("R8 drive flipped", pad_out, 1'b0);
        chk("R7 core_din stuck", core_din, 1'b0);

        // R4 R9: capture reads flag=1 and re-arms
        step(0, 1, 0);
        chk("R4 captured fault flag", scan_out, 1'b1);
        chk("R9 capture re-arms", pad_out, 1'b1);
        step(0, 0, 0);
        chk("R8 flips again", pad_out, 1'b0);

        // R9: with protection off, after a clearing capture, drive stays
        unstress_en = 1'b0;
        step(0, 1, 0);
        repeat (3) step(0, 0, 0);
        chk("R9 no flip when disabled", pad_out, 1'b1);
        stuck_en = 1'b0;

        // R2: functional mode ignores scan activity
        mode = 1'b0; core_dout = 1'b0; core_oe = 1'b1;
        scan_in = 1; step(1, 0, 1);
        chk("R2 pad_out from core", pad_out, 1'b0);
        chk("R2 pad_oe from core", pad_oe, 1'b1);

        // R10: clock variant captures and shifts
        ext_c = 1'b1; step(0, 1, 0);
        chk("R10 clk capture", scan_out_c, 1'b1);
        scan_in = 1'b0; step(1, 0, 0);
        chk("R10 clk shift", scan_out_c, 1'b0);
        chk("R10 clk pad_out", pad_out_c, 1'b0);

        // constrained random mix checked against the model
        for (int i = 0; i < N_RANDOM; i++) begin
            int op;
            mode        = ($urandom % 4) != 0;
            unstress_en = ($urandom % 3) != 0;
            scan_in     = $urandom % 2;
            core_dout   = $urandom % 2;
            core_oe     = $urandom % 2;
            ext_val     = $urandom % 2;
            ext_c       = $urandom % 2;
            stuck_en    = ($urandom % 4) == 0;
            stuck_val   = $urandom % 2;
            op          = $urandom % 5;
            case (op)
                0: step(1, 0, 0);
                1: step(0, 1, 0);
                2: step(0, 0, 1);
                3: step(1, 1, 0);
                default: step(0, 0, 0);
            endcase
            check_all();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule